// File: doc/BRIEF.md
# SMBus Byte-Data Read Host

This block is a small register-mapped host for a two-wire management bus. It performs one kind of transfer: reading one data byte from a slave at a given command code. A processor loads the slave address and the command code, then starts the transfer with a write to the control register. The block then runs the whole bus sequence on its own. It sends a start condition, the slave address in write direction and the command byte. It follows these with a repeated start and the address in read direction. It then takes in one byte, answers it with a not-acknowledge and closes with a stop condition.

Both bus lines are open-drain. The block pulls a line low by raising its enable output and reads the data line back through an input. The SCL half-period is a parameter counted in system clocks. Software watches the busy flag in the status register. When the flag clears, the transfer succeeded only if the status reads exactly 0x02. Status flags are cleared by writing ones to them, so writing back the value just read clears them all.

Top module: `smbus_rd_host`

## Requirements
- R1: After reset every register reads 0x00, both line enables `scl_oe` and `sda_oe` are 0, and `irq` is 0.
- R2: Register offsets are: status 0, control 2, command 3, slave address 4, data0 5, data1 6, block data 7. Offsets 3, 4, 6 and 7 read back the value last written. Offset 1 always reads 0x00. Control reads back what was written, except that bit 6 always reads 0.
- R3: Writing the control register with bit 6 = 1 and bits 4:2 = 010, while status bit 0 (busy) is 0, starts a transfer. Busy then reads 1 until the transfer has ended.
- R4: A control write with bit 6 = 1 is ignored if bits 4:2 hold any value other than 010, or if a transfer is already running. No transfer starts and a running one is not restarted.
- R5: The bus sequence is: start, then the 7-bit address from slave-address bits 7:1 with direction 0 (the written bit 0 is ignored), then an acknowledge slot. Next come the command byte, an acknowledge slot and a repeated start. Then the address goes out with direction 1, followed by an acknowledge slot and eight received bits, MSB first. The master leaves SDA released in the ninth slot (not-acknowledge), then sends a stop. Bits go out MSB first. SCL rising edges during a byte are 2×`HALF_CLKS` system clocks apart.
- R6: On success the received byte is in data0 while busy is still 1. Status bit 1 (done) is set in the same cycle that busy clears, and the status then reads exactly 0x02. Between transfers, data0 changes only through a register write.
- R7: If the slave does not acknowledge the address or the command byte, the block sends a stop without a repeated start and leaves data0 unchanged. It ends with status bit 2 (error) and done set, so the status reads 0x06.
- R8: A status write clears each of bits 1 and 2 that is written as 1. A bit written as 0 keeps its value, and the write has no effect on bit 0.
- R9: `irq` equals control bit 0 AND status bit 1.
- R10: While SCL is released, SDA changes only as part of a start, repeated-start or stop condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt: done flag gated by the interrupt enable |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
The assertions check on every cycle the properties that hold whatever the slave does. They check that SDA stays quiet while SCL is high except in start, repeated-start and stop conditions, and that done rises only in the cycle busy falls. They also check that data0 never moves between transfers unless it is written, that no byte is delivered after an unacknowledged phase, and that the half-period counter stays in range. The bench's slave model covers what needs a partner on the bus. It checks the order of frames and direction bits, the acknowledge and not-acknowledge slots, the byte that arrives, the exact 0x02 and 0x06 end codes, the start writes that must be ignored, and the write-one-to-clear rules.

// File: rtl/smbus_rd_pkg.sv
package smbus_rd_pkg;

  localparam int RegAw = 3;
  localparam int DataW = 8;

  localparam logic [RegAw-1:0] OFS_STAT = 3'd0;
  localparam logic [RegAw-1:0] OFS_CTRL = 3'd2;
  localparam logic [RegAw-1:0] OFS_CMD  = 3'd3;
  localparam logic [RegAw-1:0] OFS_ADR  = 3'd4;
  localparam logic [RegAw-1:0] OFS_D0   = 3'd5;
  localparam logic [RegAw-1:0] OFS_D1   = 3'd6;
  localparam logic [RegAw-1:0] OFS_BLK  = 3'd7;

  localparam int CTRL_IEN_BIT   = 0;
  localparam int CTRL_GO_BIT    = 6;
  localparam logic [2:0] PROTO_BYTE_RD = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WBIT,
    ST_RSTART,
    ST_RBIT,
    ST_STOP,
    ST_FIN
  } eng_state_e;

endpackage

// File: rtl/smbus_rd_tick.sv
module smbus_rd_tick #(
  parameter int HALF_CLKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the half-period counter never runs past its terminal value
  assert_tick_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/smbus_rd_engine.sv
module smbus_rd_engine
  import smbus_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [6:0] slv_adr,
  input  logic [7:0] cmd_code,
  input  logic       tick,
  input  logic       sda_in,
  output logic       busy,
  output logic       fin,
  output logic       fail,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  eng_state_e state_q, state_d;
  logic [1:0] ph_q, ph_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [1:0] idx_q, idx_d;
  logic [6:0] adr_q, adr_d;
  logic [7:0] cmd_q, cmd_d;
  logic       scl_low_q, scl_low_d;
  logic       err_q, err_d;
  logic       rxv_q, rxv_d;
  logic       sda_q, sda_lvl;
  logic [1:0] sync_q;
  logic       sda_s;

  assign sda_s = sync_q[1];

  // SDA level requested in the current state; sent out one clock later
  always_comb begin
    case (state_q)
      ST_START:  sda_lvl = 1'b0;
      ST_WBIT:   sda_lvl = (bit_q == ACK_SLOT) ? 1'b1 : sh_q[7];
      ST_RSTART: sda_lvl = (ph_q != 2'd2);
      ST_RBIT:   sda_lvl = 1'b1;
      ST_STOP:   sda_lvl = (ph_q == 2'd2);
      default:   sda_lvl = 1'b1;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    ph_d      = ph_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    idx_d     = idx_q;
    adr_d     = adr_q;
    cmd_d     = cmd_q;
    scl_low_d = scl_low_q;
    err_d     = err_q;
    rxv_d     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        scl_low_d = 1'b0;
        if (go) begin
          state_d = ST_START;
          adr_d   = slv_adr;
          cmd_d   = cmd_code;
          err_d   = 1'b0;
          ph_d    = 2'd0;
        end
      end
      ST_START: begin
        if (tick) begin
          scl_low_d = 1'b1;
          state_d   = ST_WBIT;
          bit_d     = 4'd0;
          ph_d      = 2'd0;
          sh_d      = {adr_q, 1'b0};
          idx_d     = 2'd0;
        end
      end
      ST_WBIT: begin
        if (tick) begin
          if (ph_q == 2'd0) begin
            scl_low_d = 1'b0;
            ph_d      = 2'd1;
          end else begin
            scl_low_d = 1'b1;
            ph_d      = 2'd0;
            if (bit_q == ACK_SLOT) begin
              if (sda_s) begin
                err_d   = 1'b1;
                state_d = ST_STOP;
              end else begin
                case (idx_q)
                  2'd0: begin
                    sh_d  = cmd_q;
                    idx_d = 2'd1;
                    bit_d = 4'd0;
                  end
                  2'd1:    state_d = ST_RSTART;
                  default: begin
                    state_d = ST_RBIT;
                    bit_d   = 4'd0;
                  end
                endcase
              end
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_RSTART: begin
        if (tick) begin
          case (ph_q)
            2'd0: begin
              scl_low_d = 1'b0;
              ph_d      = 2'd1;
            end
            2'd1: ph_d = 2'd2;
            default: begin
              scl_low_d = 1'b1;
              state_d   = ST_WBIT;
              bit_d     = 4'd0;
              ph_d      = 2'd0;
              sh_d      = {adr_q, 1'b1};
              idx_d     = 2'd2;
            end
          endcase
        end
      end
      ST_RBIT: begin
        if (tick) begin
          if (ph_q == 2'd0) begin
            scl_low_d = 1'b0;
            ph_d      = 2'd1;
          end else begin
            scl_low_d = 1'b1;
            ph_d      = 2'd0;
            if (bit_q == ACK_SLOT) begin
              rxv_d   = 1'b1;
              state_d = ST_STOP;
            end else begin
              sh_d  = {sh_q[6:0], sda_s};
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          case (ph_q)
            2'd0: begin
              scl_low_d = 1'b0;
              ph_d      = 2'd1;
            end
            2'd1:    ph_d    = 2'd2;
            default: state_d = ST_FIN;
          endcase
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ph_q      <= 2'd0;
      bit_q     <= 4'd0;
      sh_q      <= 8'h00;
      idx_q     <= 2'd0;
      adr_q     <= 7'h00;
      cmd_q     <= 8'h00;
      scl_low_q <= 1'b0;
      err_q     <= 1'b0;
      rxv_q     <= 1'b0;
      sda_q     <= 1'b1;
      sync_q    <= 2'b11;
    end else begin
      state_q   <= state_d;
      ph_q      <= ph_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      idx_q     <= idx_d;
      adr_q     <= adr_d;
      cmd_q     <= cmd_d;
      scl_low_q <= scl_low_d;
      err_q     <= err_d;
      rxv_q     <= rxv_d;
      sda_q     <= sda_lvl;
      sync_q    <= {sync_q[0], sda_in};
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign fin      = (state_q == ST_FIN);
  assign fail     = err_q;
  assign rx_valid = rxv_q;
  assign rx_byte  = sh_q;
  assign scl_oe   = scl_low_q;
  assign sda_oe   = ~sda_q;

  // R10: with SCL released, SDA only moves inside start/restart/stop
  assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low_q && $past(!scl_low_q) && (sda_q != $past(sda_q)))
      |-> (state_q inside {ST_START, ST_RSTART, ST_STOP}));

  // R7: a transfer that saw a missing acknowledge never delivers a byte
  assert_no_rx_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !err_q);

  // R5: both lines are released when the transfer finishes
  assert_lines_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/smbus_rd_regs.sv
module smbus_rd_regs
  import smbus_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RegAw-1:0] reg_addr,
  input  logic             reg_we,
  input  logic [DataW-1:0] reg_wdata,
  output logic [DataW-1:0] reg_rdata,
  input  logic             eng_busy,
  input  logic             eng_fin,
  input  logic             eng_fail,
  input  logic             rx_valid,
  input  logic [DataW-1:0] rx_byte,
  output logic             go,
  output logic [6:0]       slv_adr,
  output logic [DataW-1:0] cmd_code,
  output logic             irq
);
  logic [DataW-1:0] ctrl_q, ctrl_d;
  logic [DataW-1:0] cmd_q, cmd_d;
  logic [DataW-1:0] adr_q, adr_d;
  logic [DataW-1:0] d0_q, d0_d;
  logic [DataW-1:0] d1_q, d1_d;
  logic [DataW-1:0] blk_q, blk_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             wr_stat, wr_ctrl;

  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);

  assign go = wr_ctrl && reg_wdata[CTRL_GO_BIT]
              && (reg_wdata[4:2] == PROTO_BYTE_RD) && !eng_busy;

  always_comb begin
    ctrl_d = ctrl_q;
    cmd_d  = cmd_q;
    adr_d  = adr_q;
    d0_d   = d0_q;
    d1_d   = d1_q;
    blk_d  = blk_q;
    done_d = done_q;
    err_d  = err_q;
    if (wr_ctrl) ctrl_d = reg_wdata & ~(8'h01 << CTRL_GO_BIT);
    if (reg_we && (reg_addr == OFS_CMD)) cmd_d = reg_wdata;
    if (reg_we && (reg_addr == OFS_ADR)) adr_d = reg_wdata;
    if (reg_we && (reg_addr == OFS_D0))  d0_d  = reg_wdata;
    if (reg_we && (reg_addr == OFS_D1))  d1_d  = reg_wdata;
    if (reg_we && (reg_addr == OFS_BLK)) blk_d = reg_wdata;
    if (rx_valid) d0_d = rx_byte;
    if (wr_stat) begin
      if (reg_wdata[1]) done_d = 1'b0;
      if (reg_wdata[2]) err_d  = 1'b0;
    end
    if (eng_fin) begin
      done_d = 1'b1;
      if (eng_fail) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
      adr_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      blk_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cmd_q  <= cmd_d;
      adr_q  <= adr_d;
      d0_q   <= d0_d;
      d1_q   <= d1_d;
      blk_q  <= blk_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {5'b00000, err_q, done_q, eng_busy};
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_ADR:  reg_rdata = adr_q;
      OFS_D0:   reg_rdata = d0_q;
      OFS_D1:   reg_rdata = d1_q;
      OFS_BLK:  reg_rdata = blk_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign slv_adr  = adr_q[7:1];
  assign cmd_code = cmd_q;
  assign irq      = ctrl_q[CTRL_IEN_BIT] & done_q;

  // R6: done may only rise in the cycle the engine drops busy
  assert_done_at_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(eng_busy));

  // R6: outside a transfer, data0 moves only through a register write
  assert_data0_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d0_q != $past(d0_q)) |-> ($past(eng_busy) || $past(reg_we && (reg_addr == OFS_D0))));

endmodule

// File: rtl/smbus_rd_host.sv
module smbus_rd_host
  import smbus_rd_pkg::*;
#(
  parameter int HALF_CLKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       go, tick, busy, fin, fail, rx_valid;
  logic [6:0] slv_adr;
  logic [7:0] cmd_code, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  smbus_rd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_busy  (busy),
    .eng_fin   (fin),
    .eng_fail  (fail),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .go        (go),
    .slv_adr   (slv_adr),
    .cmd_code  (cmd_code),
    .irq       (irq)
  );

  smbus_rd_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (busy),
    .tick  (tick)
  );

  smbus_rd_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .go       (go),
    .slv_adr  (slv_adr),
    .cmd_code (cmd_code),
    .tick     (tick),
    .sda_in   (sda_i),
    .busy     (busy),
    .fin      (fin),
    .fail     (fail),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );

endmodule

// File: tb/smbus_rd_host_tb.sv
module smbus_rd_host_tb;
  localparam int HALF = 5;
  localparam logic [6:0] SLV = 7'h50;
  localparam logic [2:0] A_STAT = 3'd0, A_R1 = 3'd1, A_CTRL = 3'd2, A_CMD = 3'd3,
                         A_ADR = 3'd4, A_D0 = 3'd5, A_D1 = 3'd6, A_BLK = 3'd7;
  // {command, address register, expected final status, expected data0}
  localparam logic [31:0] VEC [5] = '{
    32'h03_A1_02_59,
    32'h11_A0_02_4B,
    32'h7F_A3_06_C3,
    32'hF4_A1_06_C3,
    32'h80_A1_02_DA
  };

  logic clk, rst_n, reg_we, sda_i, irq, scl_oe, sda_oe;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  smbus_rd_host #(.HALF_CLKS(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_scl = 0, cyc = 0, rise_last = 0, rise_prev = 0;
  logic sl_pull, armed, sl_nack, scl_prev;
  logic [1:0] sl_dirs;
  logic [7:0] sl_cmd;
  wire sda_w = ~(sda_oe | sl_pull);
  wire scl_w = ~scl_oe;
  assign sda_i = sda_w;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (armed && scl_oe && !scl_prev) begin
      rise_prev = rise_last;
      rise_last = cyc;
      n_scl = n_scl + 1;
    end
    scl_prev = scl_oe;
  end

  always @(posedge sda_w) if (armed && scl_w === 1'b1) n_stop = n_stop + 1;

  task automatic sl_get(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_w);
      b = {b[6:0], sda_w};
    end
  endtask

  task automatic sl_frame();
    logic [7:0] b;
    logic [7:0] d;
    sl_get(b);
    sl_dirs = {sl_dirs[0], b[0]};
    if (b[7:1] != SLV) return;
    @(negedge scl_w); sl_pull = 1'b1;
    if (!b[0]) begin
      @(negedge scl_w); sl_pull = 1'b0;
      sl_get(b);
      sl_cmd = b;
      if (b >= 8'hF0) return;
      @(negedge scl_w); sl_pull = 1'b1;
      @(negedge scl_w); sl_pull = 1'b0;
    end else begin
      d = sl_cmd ^ 8'h5A;
      for (int i = 7; i >= 0; i--) begin
        @(negedge scl_w); sl_pull = ~d[i];
      end
      @(negedge scl_w); sl_pull = 1'b0;
      @(posedge scl_w); sl_nack = sda_w;
    end
  endtask

  initial begin
    sl_pull = 1'b0;
    sl_dirs = 2'b00;
    sl_cmd  = 8'h00;
    sl_nack = 1'b0;
    forever begin
      @(negedge sda_w);
      if (armed && scl_w === 1'b1) begin
        n_start = n_start + 1;
        sl_frame();
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clr_stat();
    logic [7:0] v;
    rd(A_STAT, v);
    wr(A_STAT, v);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] adr, input logic [7:0] ctrl,
                      output logic [7:0] st_mid, output logic [7:0] d0_mid,
                      output logic [7:0] st_end, output int ds);
    int s0, p0;
    logic [7:0] v;
    clr_stat();
    wr(A_D0, 8'hC3);
    wr(A_CMD, cmd);
    wr(A_ADR, adr);
    s0 = n_start; p0 = n_stop;
    wr(A_CTRL, ctrl);
    wait (n_stop != p0);
    rd(A_STAT, st_mid);
    rd(A_D0, d0_mid);
    do rd(A_STAT, v); while (v[0]);
    st_end = v;
    ds = n_start - s0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, sm, dm, se;
    int ds, s0, c0;
    armed = 1'b0; scl_prev = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 8'h00);
    end
    check("R1 scl_oe reset", scl_oe, 1'b0);
    check("R1 sda_oe reset", sda_oe, 1'b0);
    check("R1 irq reset", irq, 1'b0);

    // R2: register map and read-back
    wr(A_CMD, 8'h3C); rd(A_CMD, v); check("R2 command readback", v, 8'h3C);
    wr(A_ADR, 8'h96); rd(A_ADR, v); check("R2 address readback", v, 8'h96);
    wr(A_D1, 8'h5E);  rd(A_D1, v);  check("R2 data1 readback", v, 8'h5E);
    wr(A_BLK, 8'hE7); rd(A_BLK, v); check("R2 block readback", v, 8'hE7);
    wr(A_R1, 8'hFF);  rd(A_R1, v);  check("R2 offset1 reads zero", v, 8'h00);

    // R4: start with wrong protocol code is ignored; R2 control bit 6 reads 0
    c0 = n_scl; s0 = n_start;
    wr(A_CTRL, 8'hC5);
    rd(A_CTRL, v); check("R2 control readback bit6 clear", v, 8'h85);
    repeat (30) @(negedge clk);
    rd(A_STAT, v); check("R4 wrong protocol no busy", v, 8'h00);
    check("R4 wrong protocol no SCL activity", n_scl - c0, 0);
    check("R4 wrong protocol no start", n_start - s0, 0);
    wr(A_CTRL, 8'h00);

    // R5 R6 R7: table of transfers
    foreach (VEC[i]) begin
      xfer(VEC[i][31:24], VEC[i][23:16], 8'h48, sm, dm, se, ds);
      check("R6 busy still set at stop", sm, 8'h01);
      check("R6 R7 data0 before busy clears", dm, VEC[i][7:0]);
      check("R6 R7 final status", se, VEC[i][15:8]);
      rd(A_D0, v); check("R6 R7 data0 after transfer", v, VEC[i][7:0]);
      check("R5 R7 start conditions", ds, (VEC[i][15:8] == 8'h02) ? 2 : 1);
      if (VEC[i][15:8] == 8'h02) begin
        check("R5 direction bits write then read", sl_dirs, 2'b01);
        check("R5 command byte on bus", sl_cmd, VEC[i][31:24]);
        check("R5 final not-acknowledge", sl_nack, 1'b1);
        check("R5 SCL period", rise_last - rise_prev, 2 * HALF);
      end
    end

    // R8: write-one-to-clear on status (last transfer left 0x02)
    wr(A_STAT, 8'h01); rd(A_STAT, v); check("R8 bit0 write no effect", v, 8'h02);
    wr(A_STAT, 8'h00); rd(A_STAT, v); check("R8 zero write keeps done", v, 8'h02);
    wr(A_STAT, 8'h02); rd(A_STAT, v); check("R8 clear done", v, 8'h00);
    xfer(8'h22, 8'hA5, 8'h48, sm, dm, se, ds);
    check("R7 address nack status", se, 8'h06);
    wr(A_STAT, 8'h04); rd(A_STAT, v); check("R8 clear error only", v, 8'h02);
    wr(A_STAT, 8'h02); rd(A_STAT, v); check("R8 clear remaining", v, 8'h00);

    // R9: interrupt follows enable and done
    xfer(8'h40, 8'hA1, 8'h49, sm, dm, se, ds);
    check("R9 status for irq run", se, 8'h02);
    check("R9 irq set with done", irq, 1'b1);
    wr(A_STAT, 8'h02);
    rd(A_STAT, v);
    check("R9 irq drops with done", irq, 1'b0);
    wr(A_STAT, 8'h00);
    xfer(8'h41, 8'hA1, 8'h48, sm, dm, se, ds);
    check("R9 irq disabled", irq, 1'b0);

    // R3 R4: start flag and start while busy
    clr_stat();
    wr(A_CMD, 8'h07); wr(A_ADR, 8'hA1);
    s0 = n_start;
    wr(A_CTRL, 8'h48);
    rd(A_STAT, v); check("R3 busy after start", v, 8'h01);
    repeat (40) @(negedge clk);
    wr(A_CTRL, 8'h48);
    rd(A_STAT, v); check("R3 busy during transfer", v[0], 1'b1);
    do rd(A_STAT, v); while (v[0]);
    check("R4 restart ignored status", v, 8'h02);
    check("R4 restart ignored starts", n_start - s0, 2);
    rd(A_D0, v); check("R4 restart ignored data0", v, 8'h07 ^ 8'h5A);
    repeat (30) @(negedge clk);
    check("R4 no further start", n_start - s0, 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule